// File: doc/BRIEF.md
# Channel-Access Transmit Retry Sequencer

This block runs one unslotted carrier-sense channel-access attempt for a single outgoing frame and then waits for the acknowledgement. A start pulse launches the sequence. Two packed configuration bytes supply the retry limits and the backoff exponent range. The block waits a random number of backoff unit periods, requests a clear channel assessment, and uses the busy or idle answer either to back off again with a larger exponent or to trigger transmission. After the transmitter reports completion, it opens a bounded acknowledgement window. If the window expires, the whole channel-access procedure starts again from the minimum exponent.

The block finishes in one of four outcomes and reports it as a 2-bit status code. On completion it also raises the completion interrupt flag at bit 7 of an interrupt source byte. The radio, modulation, frame contents and CRC all live elsewhere. The assessment result, the transmit-done strobe and the acknowledgement strobe reach the block as plain inputs.

Top module: `csma_tx_sequencer`

## Requirements
- R1: `cfg_retry[3:0]` is the frame retry limit and `cfg_retry[6:4]` is the assessment retry limit. `cfg_backoff[3:0]` is the maximum exponent and `cfg_backoff[7:4]` is the minimum exponent. A start is accepted only when min <= max, max <= 8 and the assessment limit <= 5. A start with any other setting leaves `busy` and `cca_req` low.
- R2: An accepted start raises `busy` on the next clock. With an exponent of 0, `cca_req` rises three clocks after the start was sampled.
- R3: Before each assessment the block waits S unit periods of `UNIT_CYCLES` clocks each, where S is drawn from a 16-bit LFSR in the range 0 to 2^BE-1. The gap from the triggering event to `cca_req` is therefore 3 + S*UNIT_CYCLES clocks.
- R4: The exponent starts at the minimum and rises by one after each busy assessment, saturating at the maximum. An idle assessment (`cca_done` with `cca_busy` low) raises `tx_req` on the next clock.
- R5: When the number of busy assessments in one attempt exceeds the assessment limit, the sequence ends with status 2. This takes limit+1 assessments.
- R6: An `ack_rcvd` inside the window ends the sequence on the next clock. The status is 1 if `ack_pending` was high and 0 if it was low.
- R7: The acknowledgement window is `ACK_WAIT_CYCLES` clocks after `tx_done`. When it expires, the block restarts the procedure with the exponent back at the minimum and a fresh busy count. After frame limit+1 unanswered transmissions, the status is 3.
- R8: In the clock where the status is posted, `busy` falls and `irq_src` becomes 8'h80. The flag clears when the next start is accepted.
- R9: A start pulse while `busy` is high is ignored, and its configuration does not replace the running one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (one-clock pulse) |
| cfg_retry | input | 8 | Frame retry limit [3:0], assessment retry limit [6:4] |
| cfg_backoff | input | 8 | Maximum exponent [3:0], minimum exponent [7:4] |
| cca_req | output | 1 | One-clock request for a clear channel assessment |
| cca_done | input | 1 | Assessment result strobe |
| cca_busy | input | 1 | Assessment result, 1 = channel busy, valid with cca_done |
| tx_req | output | 1 | One-clock transmit trigger |
| tx_done | input | 1 | Transmission finished strobe |
| ack_rcvd | input | 1 | Acknowledgement received strobe |
| ack_pending | input | 1 | Frame-pending bit of the acknowledgement, valid with ack_rcvd |
| busy | output | 1 | High from an accepted start until the status is posted |
| status | output | 2 | 0 success, 1 success with pending, 2 channel busy, 3 no acknowledgement |
| irq_src | output | 8 | Interrupt source byte, bit 7 = sequence complete |

## Verification
Every result is due a fixed number of clocks after the strobe that causes it. Each strobe is driven for one clock on a falling edge, and the outputs are sampled on later falling edges. The status, `busy` and `irq_src` are checked on the first falling edge after the clock that sampled `ack_rcvd`. `tx_req` is checked one clock after an idle assessment. With an exponent of 0, `cca_req` is checked exactly three clocks after start or after a busy answer. After a window expiry, `cca_req` is checked at `ACK_WAIT_CYCLES`+3 clocks. On the last attempt, the window is checked to be still open at clock `ACK_WAIT_CYCLES` and closed one clock later. Because random backoff cannot be predicted, each gap for a nonzero exponent is checked against the bound 3 + (2^BE-1)*UNIT_CYCLES for the exponent in force.

// File: rtl/csma_seq_pkg.sv
// Shared types for the channel-access sequencer: configuration fields,
// outcome codes and controller states. Assumes bytes are packed as the
// register format fixes them.
package csma_seq_pkg;

    localparam int CFG_BYTE_W  = 8;
    localparam int IRQ_BYTE_W  = 8;
    localparam int IRQ_DONE_BIT = 7;
    localparam int BE_W        = 4;
    localparam int CCA_CNT_W   = 3;
    localparam int FRM_CNT_W   = 4;
    localparam int BE_LIMIT    = 8;
    localparam int CCA_LIMIT   = 5;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_OK_PEND  = 2'd1,
        RES_CHAN_BSY = 2'd2,
        RES_NO_ACK   = 2'd3
    } csma_result_e;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_WAIT, S_CCA_REQ, S_CCA_WAIT,
        S_TX_REQ, S_TX_WAIT, S_ACK_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [FRM_CNT_W-1:0] frame_max;
        logic [CCA_CNT_W-1:0] cca_max;
        logic [BE_W-1:0]      be_max;
        logic [BE_W-1:0]      be_min;
    } csma_cfg_t;

    // Split the two configuration bytes into their fields.
    function automatic csma_cfg_t unpack_cfg(input logic [CFG_BYTE_W-1:0] r_retry,
                                             input logic [CFG_BYTE_W-1:0] r_boff);
        csma_cfg_t c;
        c.frame_max = r_retry[3:0];
        c.cca_max   = r_retry[6:4];
        c.be_max    = r_boff[3:0];
        c.be_min    = r_boff[7:4];
        return c;
    endfunction

    // Legal combination check applied before a start is accepted.
    function automatic logic cfg_legal(input csma_cfg_t c);
        return (c.be_min <= c.be_max) &&
               (c.be_max <= BE_W'(BE_LIMIT)) &&
               (c.cca_max <= CCA_CNT_W'(CCA_LIMIT));
    endfunction

endpackage

// File: rtl/csma_lfsr.sv
// Free-running Galois LFSR used as the backoff random source.
// Assumes a nonzero seed; only the low OUT_W bits leave the module.
module csma_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 8,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] state_q;

    // Advance one step every clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (state_q[0])
            state_q <= (state_q >> 1) ^ TAPS;
        else
            state_q <= state_q >> 1;
    end

    assign rnd = state_q[OUT_W-1:0];

    p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/csma_backoff.sv
// Backoff timer: on load it takes a random slot count masked to
// 2^be-1, then counts slots of UNIT_CYCLES clocks. 'expired' is high
// while no slots remain. Assumes be <= SLOT_W.
module csma_backoff #(
    parameter int UNIT_CYCLES = 20,
    parameter int SLOT_W      = 8,
    parameter int BE_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BE_W-1:0]   be,
    input  logic [SLOT_W-1:0] rnd,
    output logic              expired
);
    localparam int UW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [UW-1:0] UNIT_LAST = UW'(UNIT_CYCLES - 1);

    logic [SLOT_W:0]   mask_full;
    logic [SLOT_W-1:0] mask;
    logic [SLOT_W-1:0] slots_q;
    logic [UW-1:0]     unit_q;

    // Slot mask 2^be-1 for the exponent in force.
    always_comb begin
        mask_full = ({{SLOT_W{1'b0}}, 1'b1} << be) - 1'b1;
        mask      = mask_full[SLOT_W-1:0];
    end

    // Load the slot count, then tick it down once per unit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
            unit_q  <= '0;
        end else if (load) begin
            slots_q <= rnd & mask;
            unit_q  <= UNIT_LAST;
        end else if (slots_q != '0) begin
            if (unit_q == '0) begin
                unit_q  <= UNIT_LAST;
                slots_q <= slots_q - 1'b1;
            end else begin
                unit_q <= unit_q - 1'b1;
            end
        end
    end

    assign expired = (slots_q == '0);

    p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (slots_q <= $past(mask)));

endmodule

// File: rtl/csma_ctrl.sv
// Sequencing controller: accepts a legal start, walks backoff, channel
// assessment, transmit and acknowledgement window, counts busy answers
// and frame retries, and posts the outcome plus the completion flag.
// Assumes the strobes are one clock wide.
module csma_ctrl
    import csma_seq_pkg::*;
#(
    parameter int ACK_WAIT_CYCLES = 54
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  csma_cfg_t       cfg_in,
    input  logic            cfg_ok,
    input  logic            backoff_expired,
    output logic            backoff_load,
    output logic [BE_W-1:0] be,
    output logic            cca_req,
    input  logic            cca_done,
    input  logic            cca_busy,
    output logic            tx_req,
    input  logic            tx_done,
    input  logic            ack_rcvd,
    input  logic            ack_pending,
    output logic            busy,
    output logic [1:0]      result,
    output logic            done_flag
);
    localparam int AW = $clog2(ACK_WAIT_CYCLES + 1);
    localparam logic [AW-1:0] ACK_LAST = AW'(ACK_WAIT_CYCLES - 1);

    seq_state_e           state_q;
    csma_cfg_t            cfg_q;
    logic [BE_W-1:0]      be_q;
    logic [CCA_CNT_W-1:0] nb_q;
    logic [FRM_CNT_W-1:0] nr_q;
    logic [AW-1:0]        ack_cnt_q;
    csma_result_e         result_q;
    logic                 flag_q;

    // Main sequence: state, counters, exponent and posted outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cfg_q     <= '0;
            be_q      <= '0;
            nb_q      <= '0;
            nr_q      <= '0;
            ack_cnt_q <= '0;
            result_q  <= RES_OK;
            flag_q    <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start && cfg_ok) begin
                    cfg_q   <= cfg_in;
                    be_q    <= cfg_in.be_min;
                    nb_q    <= '0;
                    nr_q    <= '0;
                    flag_q  <= 1'b0;
                    state_q <= S_LOAD;
                end
                S_LOAD:    state_q <= S_WAIT;
                S_WAIT:    if (backoff_expired) state_q <= S_CCA_REQ;
                S_CCA_REQ: state_q <= S_CCA_WAIT;
                S_CCA_WAIT: if (cca_done) begin
                    if (!cca_busy) begin
                        state_q <= S_TX_REQ;
                    end else if (nb_q >= cfg_q.cca_max) begin
                        result_q <= RES_CHAN_BSY;
                        flag_q   <= 1'b1;
                        state_q  <= S_IDLE;
                    end else begin
                        nb_q    <= nb_q + 1'b1;
                        be_q    <= (be_q < cfg_q.be_max) ? be_q + 1'b1 : be_q;
                        state_q <= S_LOAD;
                    end
                end
                S_TX_REQ:  state_q <= S_TX_WAIT;
                S_TX_WAIT: if (tx_done) begin
                    ack_cnt_q <= ACK_LAST;
                    state_q   <= S_ACK_WAIT;
                end
                S_ACK_WAIT: begin
                    if (ack_rcvd) begin
                        result_q <= ack_pending ? RES_OK_PEND : RES_OK;
                        flag_q   <= 1'b1;
                        state_q  <= S_IDLE;
                    end else if (ack_cnt_q == '0) begin
                        if (nr_q >= cfg_q.frame_max) begin
                            result_q <= RES_NO_ACK;
                            flag_q   <= 1'b1;
                            state_q  <= S_IDLE;
                        end else begin
                            nr_q    <= nr_q + 1'b1;
                            nb_q    <= '0;
                            be_q    <= cfg_q.be_min;
                            state_q <= S_LOAD;
                        end
                    end else begin
                        ack_cnt_q <= ack_cnt_q - 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Output decode from the state register.
    always_comb begin
        backoff_load = (state_q == S_LOAD);
        cca_req      = (state_q == S_CCA_REQ);
        tx_req       = (state_q == S_TX_REQ);
        busy         = (state_q != S_IDLE);
        be           = be_q;
        result       = result_q;
        done_flag    = flag_q;
    end

    p_be_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (be_q >= cfg_q.be_min) && (be_q <= cfg_q.be_max));

    p_cca_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (nb_q <= cfg_q.cca_max));

    p_frame_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (nr_q <= cfg_q.frame_max));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(cfg_q));

endmodule

// File: rtl/csma_tx_sequencer.sv
// Top of the channel-access transmit sequencer: decodes the two
// configuration bytes, ties the random source and backoff timer to the
// controller and forms the interrupt source byte. Assumes all inputs
// are synchronous to clk.
module csma_tx_sequencer
    import csma_seq_pkg::*;
#(
    parameter int UNIT_CYCLES     = 20,
    parameter int ACK_WAIT_CYCLES = 54,
    parameter int SLOT_W          = 8,
    parameter int LFSR_W          = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CFG_BYTE_W-1:0] cfg_retry,
    input  logic [CFG_BYTE_W-1:0] cfg_backoff,
    output logic                  cca_req,
    input  logic                  cca_done,
    input  logic                  cca_busy,
    output logic                  tx_req,
    input  logic                  tx_done,
    input  logic                  ack_rcvd,
    input  logic                  ack_pending,
    output logic                  busy,
    output logic [1:0]            status,
    output logic [IRQ_BYTE_W-1:0] irq_src
);
    csma_cfg_t         cfg_dec;
    logic              cfg_ok;
    logic [SLOT_W-1:0] rnd;
    logic              bo_load;
    logic              bo_expired;
    logic [BE_W-1:0]   be;
    logic              done_flag;

    // Field split and legality check of the configuration bytes.
    always_comb begin
        cfg_dec = unpack_cfg(cfg_retry, cfg_backoff);
        cfg_ok  = cfg_legal(cfg_dec);
    end

    csma_lfsr #(.W(LFSR_W), .OUT_W(SLOT_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    csma_backoff #(.UNIT_CYCLES(UNIT_CYCLES), .SLOT_W(SLOT_W), .BE_W(BE_W)) u_backoff (
        .clk(clk), .rst_n(rst_n), .load(bo_load), .be(be), .rnd(rnd),
        .expired(bo_expired)
    );

    csma_ctrl #(.ACK_WAIT_CYCLES(ACK_WAIT_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_dec),
        .cfg_ok(cfg_ok), .backoff_expired(bo_expired), .backoff_load(bo_load),
        .be(be), .cca_req(cca_req), .cca_done(cca_done), .cca_busy(cca_busy),
        .tx_req(tx_req), .tx_done(tx_done), .ack_rcvd(ack_rcvd),
        .ack_pending(ack_pending), .busy(busy), .result(status),
        .done_flag(done_flag)
    );

    // Interrupt byte carries only the completion flag.
    always_comb begin
        irq_src = '0;
        irq_src[IRQ_DONE_BIT] = done_flag;
    end

    p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_irq_on_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_src[IRQ_DONE_BIT]);

endmodule

// File: tb/csma_tx_sequencer_bench.sv
`timescale 1ns/1ps
module csma_tx_sequencer_bench;
    localparam int U = 8;
    localparam int W = 12;
    localparam int LIM = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cfg_retry = 8'h00;
    logic [7:0] cfg_backoff = 8'h00;
    logic cca_done = 1'b0, cca_busy = 1'b0, tx_done = 1'b0;
    logic ack_rcvd = 1'b0, ack_pending = 1'b0;
    logic cca_req, tx_req, busy;
    logic [1:0] status;
    logic [7:0] irq_src;
    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    csma_tx_sequencer #(.UNIT_CYCLES(U), .ACK_WAIT_CYCLES(W)) u_csma_tx_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_retry(cfg_retry),
        .cfg_backoff(cfg_backoff), .cca_req(cca_req), .cca_done(cca_done),
        .cca_busy(cca_busy), .tx_req(tx_req), .tx_done(tx_done),
        .ack_rcvd(ack_rcvd), .ack_pending(ack_pending), .busy(busy),
        .status(status), .irq_src(irq_src)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [7:0] r1, input logic [7:0] r2);
        @(negedge clk);
        cfg_retry = r1; cfg_backoff = r2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_cca(input bit b);
        @(negedge clk); cca_done = 1'b1; cca_busy = b;
        @(negedge clk); cca_done = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_ack(input bit p);
        @(negedge clk); ack_rcvd = 1'b1; ack_pending = p;
        @(negedge clk); ack_rcvd = 1'b0;
    endtask

    task automatic wait_cca(output int g);
        g = 0;
        while (!cca_req && g < LIM) begin @(negedge clk); g++; end
    endtask

    task automatic wait_tx(output int g);
        g = 0;
        while (!tx_req && g < LIM) begin @(negedge clk); g++; end
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R8 reset busy", busy, 0);
        chk(cca_req == 1'b0 && tx_req == 1'b0, "R2 reset requests", cca_req + tx_req, 0);
        chk(status == 2'd0, "R6 reset status", status, 0);
        chk(irq_src == 8'h00, "R8 reset irq", irq_src, 0);
    endtask

    task automatic t_invalid();
        logic [7:0] r1s [3] = '{8'h00, 8'h00, 8'h60};
        logic [7:0] r2s [3] = '{8'h21, 8'h09, 8'h00};
        int g;
        for (int i = 0; i < 3; i++) begin
            int seen = 0;
            pulse_start(r1s[i], r2s[i]);
            for (int c = 0; c < 20; c++) begin
                if (busy || cca_req) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R1 illegal config ignored", seen, 0);
        end
        // Edge of the legal range: exponent 8, assessment limit 5.
        pulse_start(8'h5F, 8'h88);
        chk(busy == 1'b1, "R1 legal edge config accepted", busy, 1);
        for (int k = 0; k < 6; k++) begin
            wait_cca(g);
            chk(g <= 2 + 255 * U, "R3 exponent 8 backoff bound", g, 2 + 255 * U);
            pulse_cca(1'b1);
        end
        chk(busy == 1'b0 && status == 2'd2, "R5 exponent 8 channel failure", status, 2);
    endtask

    task automatic t_success(input bit pend);
        int g;
        pulse_start(8'h00, 8'h00);
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(irq_src == 8'h00, "R8 irq cleared on start", irq_src, 0);
        wait_cca(g);
        chk(g == 2, "R2 cca_req three clocks after start", g, 2);
        pulse_cca(1'b0);
        wait_tx(g);
        chk(g == 0, "R4 idle assessment triggers tx", g, 0);
        pulse_tx();
        chk(busy == 1'b1 && irq_src == 8'h00, "R8 no flag before ack", irq_src, 0);
        pulse_ack(pend);
        chk(busy == 1'b0, "R6 done one clock after ack", busy, 0);
        chk(status == {1'b0, pend}, "R6 status from ack", status, pend);
        chk(irq_src == 8'h80, "R8 completion flag", irq_src, 8'h80);
    endtask

    task automatic t_start_while_busy();
        int g;
        int n = 0;
        pulse_start(8'h20, 8'h00);
        wait_cca(g);
        n++;
        pulse_cca(1'b1);
        pulse_start(8'h50, 8'h00);
        chk(busy == 1'b1, "R9 still busy after second start", busy, 1);
        while (busy && n < 10) begin
            wait_cca(g);
            if (g >= LIM) break;
            n++;
            pulse_cca(1'b1);
        end
        chk(n == 3, "R9 R5 assessments with limit 2", n, 3);
        chk(busy == 1'b0 && status == 2'd2, "R5 channel failure status", status, 2);
    endtask

    task automatic t_backoff_bounds();
        int g;
        pulse_start(8'h50, 8'h13);
        for (int k = 0; k < 6; k++) begin
            int bek = (1 + k > 3) ? 3 : 1 + k;
            int bnd = 2 + ((1 << bek) - 1) * U;
            wait_cca(g);
            chk(g >= 2 && g <= bnd, "R3 R4 backoff gap within exponent bound", g, bnd);
            pulse_cca(1'b1);
        end
        chk(busy == 1'b0 && status == 2'd2, "R5 six assessments then failure", status, 2);
        chk(irq_src == 8'h80, "R8 flag on channel failure", irq_src, 8'h80);
    endtask

    task automatic t_no_ack();
        int g;
        pulse_start(8'h02, 8'h00);
        for (int a = 0; a < 3; a++) begin
            wait_cca(g);
            chk(g == ((a == 0) ? 2 : W + 2), "R7 retry restarts after window", g,
                (a == 0) ? 2 : W + 2);
            pulse_cca(1'b0);
            wait_tx(g);
            chk(g == 0, "R4 tx after idle assessment", g, 0);
            pulse_tx();
        end
        repeat (W - 1) @(negedge clk);
        chk(busy == 1'b1, "R7 window still open at its last clock", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0 && status == 2'd3, "R7 no-ack status after retries", status, 3);
        chk(irq_src == 8'h80, "R8 flag on no-ack", irq_src, 8'h80);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_invalid();
        repeat (3) @(negedge clk);
        t_success(1'b0);
        repeat (3) @(negedge clk);
        t_success(1'b1);
        repeat (3) @(negedge clk);
        t_start_while_busy();
        repeat (3) @(negedge clk);
        t_backoff_bounds();
        repeat (3) @(negedge clk);
        t_no_ack();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule